// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit sits beside the control sequencer of an 8-bit processor core. It arbitrates five interrupt sources. The first is a non-maskable trap. The next three are restart sources (high, mid, low) that the unit vectors itself. The last is a general request line, whose service routine is reached through an external acknowledge cycle. The core pulses `sample_i` in the next-to-last clock of every instruction. That pulse is the only moment at which requests are judged. When a source wins, the unit answers in the following cycle with a one-cycle grant. The grant carries an accept pulse, a program-counter increment inhibit, and either a restart target address or a request for the core to run an acknowledge cycle instead of an opcode read.

The unit holds a global interrupt enable flag and three mask bits, one per restart source. It also holds an edge latch for the high restart source and an arming flop that qualifies trap edges. The core drives explicit enable and disable commands and a mask-write command, and can read a status word at any time.

The controller has three states. `ST_IDLE` waits for a sample strobe. It goes to `ST_VECTOR` when the trap or a restart source wins, and to `ST_ACKCYC` when the general request wins; with no winner, it stays in `ST_IDLE`. Both grant states return to `ST_IDLE` after exactly one cycle, and a sample strobe seen during a grant state is ignored.

Top module: `irq_prio_unit`

## Requirements
- R1: After reset, `accept_o`, `pc_inhibit_o` and `ack_req_o` are 0, `vector_o` is 0, and `status_o` reads 7'b0111000: enable flag clear, all three restart masks set, nothing pending.
- R2: When several eligible sources are present at a sample, exactly one wins, in this order from highest to lowest: trap, restart-high, restart-mid, restart-low, general request.
- R3: The trap is accepted regardless of the enable flag and of all mask bits.
- R4: Requests are judged only on a clock edge at which `sample_i` is 1 and the unit is idle. The grant (`accept_o`=1) appears in the cycle right after that edge and lasts exactly one cycle.
- R5: `pc_inhibit_o` is 1 in exactly the cycles in which `accept_o` is 1.
- R6: A trap or restart grant has `ack_req_o`=0, and `vector_o` is 0x0024 for the trap, 0x003C for restart-high, 0x0034 for restart-mid and 0x002C for restart-low.
- R7: A general-request grant has `ack_req_o`=1 and `vector_o`=0.
- R8: Acceptance of any maskable source clears the enable flag on the same edge. Trap acceptance leaves the flag unchanged.
- R9: `ei_cmd_i` sets the enable flag and `di_cmd_i` clears it. When both are given in the same cycle, the disable wins. The restart sources and the general request are eligible only while the flag is 1.
- R10: `mask_wr_i` loads the mask bits from `mask_wdata_i`: bit 2 masks restart-high, bit 1 masks restart-mid and bit 0 masks restart-low, with 1 meaning masked.
- R11: A rising edge on `rst_hi_i` sets a pending latch, whether or not that source is masked. The latch is cleared by the acceptance of restart-high, or by a mask write with `mask_wdata_i[3]`=1. A level held high does not set the latch again.
- R12: Restart-mid and restart-low are level sensitive. They count only while their input is high at the sample edge.
- R13: The trap is accepted only after a rising edge on `trap_i`, with `trap_i` still high at the sample edge. A trap pulse that falls before the sample is dropped, and a trap held high is accepted only once.
- R14: `status_o` is {enable flag, mask high, mask mid, mask low, high latch, `rst_mid_i`, `rst_lo_i`}, with the enable flag in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Next-to-last clock of the current instruction |
| trap_i | input | 1 | Non-maskable trap request |
| rst_hi_i | input | 1 | Restart-high request (edge triggered) |
| rst_mid_i | input | 1 | Restart-mid request (level) |
| rst_lo_i | input | 1 | Restart-low request (level) |
| gen_req_i | input | 1 | General request needing an acknowledge cycle |
| ei_cmd_i | input | 1 | Set the enable flag |
| di_cmd_i | input | 1 | Clear the enable flag |
| mask_wr_i | input | 1 | Load masks and optionally clear the high latch |
| mask_wdata_i | input | 4 | Bit 3 clears the high latch; bits 2..0 are masks high/mid/low |
| accept_o | output | 1 | One-cycle grant |
| pc_inhibit_o | output | 1 | Suppress program-counter increment |
| ack_req_o | output | 1 | Run an acknowledge cycle instead of an opcode read |
| vector_o | output | 16 | Restart target address during a vectored grant |
| status_o | output | 7 | Enable flag, masks and pending bits |

## Verification
Every grant output is due one cycle after the clock edge at which `sample_i` was 1. The enable flag, the high latch and the masks in `status_o` change on that same edge. The bench drives inputs on the falling edge, so the decision is taken at the next rising edge, and it reads results on the falling edge after that rising edge. It then checks one more falling edge later that the grant has gone. The sweep covers every combination of the five request levels, the enable flag and the three masks, and each grant and status word is compared with values the bench derives from the priority rules.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VECTOR,
        ST_ACKCYC
    } irq_state_t;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_TRAP,
        WIN_HIGH,
        WIN_MID,
        WIN_LOW,
        WIN_GEN
    } irq_win_t;
endpackage

// File: rtl/irq_src_front.sv
module irq_src_front (
    input  logic clk,
    input  logic rst_n,
    input  logic trap_i,
    input  logic rst_hi_i,
    input  logic take_trap,
    input  logic take_hi,
    input  logic clr_hi,
    output logic trap_pend,
    output logic hi_pend,
    output logic hi_latch_q
);
    logic trap_prev_q;
    logic trap_armed_q;
    logic hi_prev_q;

    // A trap counts only while its level is still high after an edge.
    assign trap_pend = trap_i & (trap_armed_q | ~trap_prev_q);
    assign hi_pend   = hi_latch_q | (rst_hi_i & ~hi_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_prev_q  <= 1'b0;
            trap_armed_q <= 1'b0;
            hi_prev_q    <= 1'b0;
            hi_latch_q   <= 1'b0;
        end else begin
            trap_prev_q  <= trap_i;
            trap_armed_q <= trap_pend & ~take_trap;
            hi_prev_q    <= rst_hi_i;
            hi_latch_q   <= hi_pend & ~take_hi & ~clr_hi;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_RST = 3
) (
    input  logic               trap_pend,
    input  logic               hi_pend,
    input  logic               mid_lvl,
    input  logic               lo_lvl,
    input  logic               gen_lvl,
    input  logic               ie,
    input  logic [NUM_RST-1:0] mask,
    output irq_win_t           win
);
    logic [NUM_RST-1:0] rst_req;
    logic [NUM_RST-1:0] rst_ok;

    assign rst_req = {hi_pend, mid_lvl, lo_lvl};

    for (genvar i = 0; i < NUM_RST; i++) begin : g_elig
        assign rst_ok[i] = ie & ~mask[i] & rst_req[i];
    end

    always_comb begin
        if (trap_pend)                win = WIN_TRAP;
        else if (rst_ok[NUM_RST-1])   win = WIN_HIGH;
        else if (rst_ok[NUM_RST-2])   win = WIN_MID;
        else if (rst_ok[NUM_RST-3])   win = WIN_LOW;
        else if (ie & gen_lvl)        win = WIN_GEN;
        else                          win = WIN_NONE;
    end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_TRAP = 16'h0024,
    parameter logic [15:0] VEC_HIGH = 16'h003C,
    parameter logic [15:0] VEC_MID  = 16'h0034,
    parameter logic [15:0] VEC_LOW  = 16'h002C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              trap_i,
    input  logic              rst_hi_i,
    input  logic              rst_mid_i,
    input  logic              rst_lo_i,
    input  logic              gen_req_i,
    input  logic              ei_cmd_i,
    input  logic              di_cmd_i,
    input  logic              mask_wr_i,
    input  logic [3:0]        mask_wdata_i,
    output logic              accept_o,
    output logic              pc_inhibit_o,
    output logic              ack_req_o,
    output logic [ADDR_W-1:0] vector_o,
    output logic [6:0]        status_o
);
    localparam int NUM_RST = 3;

    irq_state_t         state_q, state_n;
    irq_win_t           win;
    logic               ie_q, ie_n;
    logic [NUM_RST-1:0] mask_q;
    logic [ADDR_W-1:0]  vec_q;
    logic               trap_pend, hi_pend, hi_latch_q;
    logic               take;

    assign take = sample_i && (state_q == ST_IDLE) && (win != WIN_NONE);

    irq_src_front u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_i     (trap_i),
        .rst_hi_i   (rst_hi_i),
        .take_trap  (take && win == WIN_TRAP),
        .take_hi    (take && win == WIN_HIGH),
        .clr_hi     (mask_wr_i & mask_wdata_i[3]),
        .trap_pend  (trap_pend),
        .hi_pend    (hi_pend),
        .hi_latch_q (hi_latch_q)
    );

    irq_arbiter #(.NUM_RST(NUM_RST)) u_arb (
        .trap_pend (trap_pend),
        .hi_pend   (hi_pend),
        .mid_lvl   (rst_mid_i),
        .lo_lvl    (rst_lo_i),
        .gen_lvl   (gen_req_i),
        .ie        (ie_q),
        .mask      (mask_q),
        .win       (win)
    );

    // Enable flag: disable beats enable, acceptance beats both.
    always_comb begin
        ie_n = ie_q;
        if (ei_cmd_i) ie_n = 1'b1;
        if (di_cmd_i) ie_n = 1'b0;
        if (take && win != WIN_TRAP) ie_n = 1'b0;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_n = (win == WIN_GEN) ? ST_ACKCYC : ST_VECTOR;
            end
            ST_VECTOR: state_n = ST_IDLE;
            ST_ACKCYC: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ie_q    <= 1'b0;
            mask_q  <= '1;
            vec_q   <= '0;
        end else begin
            state_q <= state_n;
            ie_q    <= ie_n;
            if (mask_wr_i) mask_q <= mask_wdata_i[NUM_RST-1:0];
            if (take) begin
                unique case (win)
                    WIN_TRAP: vec_q <= VEC_TRAP[ADDR_W-1:0];
                    WIN_HIGH: vec_q <= VEC_HIGH[ADDR_W-1:0];
                    WIN_MID:  vec_q <= VEC_MID[ADDR_W-1:0];
                    WIN_LOW:  vec_q <= VEC_LOW[ADDR_W-1:0];
                    default:  vec_q <= '0;
                endcase
            end
        end
    end

    always_comb begin
        accept_o     = 1'b0;
        pc_inhibit_o = 1'b0;
        ack_req_o    = 1'b0;
        vector_o     = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VECTOR: begin
                accept_o     = 1'b1;
                pc_inhibit_o = 1'b1;
                vector_o     = vec_q;
            end
            ST_ACKCYC: begin
                accept_o     = 1'b1;
                pc_inhibit_o = 1'b1;
                ack_req_o    = 1'b1;
            end
            default: ;
        endcase
    end

    assign status_o = {ie_q, mask_q, hi_latch_q, rst_mid_i, rst_lo_i};
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk #(
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] VEC_TRAP = 16'h0024,
    parameter logic [15:0] VEC_HIGH = 16'h003C,
    parameter logic [15:0] VEC_MID  = 16'h0034,
    parameter logic [15:0] VEC_LOW  = 16'h002C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_i,
    input logic              trap_i,
    input logic              accept_o,
    input logic              pc_inhibit_o,
    input logic              ack_req_o,
    input logic [ADDR_W-1:0] vector_o,
    input logic [6:0]        status_o
);
    p_inhibit_with_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inhibit_o == accept_o);

    p_grant_after_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(sample_i));

    p_grant_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !accept_o);

    p_ack_no_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> (accept_o && vector_o == '0));

    p_ie_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req_o |-> !status_o[6]);

    p_trap_level_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !ack_req_o && vector_o == VEC_TRAP[ADDR_W-1:0]) |-> $past(trap_i));

    p_vector_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !ack_req_o) |->
            (vector_o == VEC_TRAP[ADDR_W-1:0] || vector_o == VEC_HIGH[ADDR_W-1:0] ||
             vector_o == VEC_MID[ADDR_W-1:0]  || vector_o == VEC_LOW[ADDR_W-1:0]));
endmodule

bind irq_prio_unit irq_prio_unit_chk #(
    .ADDR_W(ADDR_W), .VEC_TRAP(VEC_TRAP), .VEC_HIGH(VEC_HIGH),
    .VEC_MID(VEC_MID), .VEC_LOW(VEC_LOW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .trap_i       (trap_i),
    .accept_o     (accept_o),
    .pc_inhibit_o (pc_inhibit_o),
    .ack_req_o    (ack_req_o),
    .vector_o     (vector_o),
    .status_o     (status_o)
);

// File: tb/tb_irq_prio_unit.sv
module tb_irq_prio_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sample_i, trap_i, rst_hi_i, rst_mid_i, rst_lo_i, gen_req_i;
    logic        ei_cmd_i, di_cmd_i, mask_wr_i;
    logic [3:0]  mask_wdata_i;
    logic        accept_o, pc_inhibit_o, ack_req_o;
    logic [15:0] vector_o;
    logic [6:0]  status_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    irq_prio_unit dut (
        .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .trap_i(trap_i),
        .rst_hi_i(rst_hi_i), .rst_mid_i(rst_mid_i), .rst_lo_i(rst_lo_i),
        .gen_req_i(gen_req_i), .ei_cmd_i(ei_cmd_i), .di_cmd_i(di_cmd_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .accept_o(accept_o), .pc_inhibit_o(pc_inhibit_o), .ack_req_o(ack_req_o),
        .vector_o(vector_o), .status_o(status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        sample_i = 0; trap_i = 0; rst_hi_i = 0; rst_mid_i = 0; rst_lo_i = 0;
        gen_req_i = 0; ei_cmd_i = 0; di_cmd_i = 0; mask_wr_i = 0; mask_wdata_i = 4'h0;
    endtask

    task automatic check_grant(input string req, input bit acc, input bit ack, input logic [15:0] vec);
        check({req, " accept"}, 32'(accept_o), 32'(acc));
        check("R5 inhibit", 32'(pc_inhibit_o), 32'(acc));
        check({req, " ack"}, 32'(ack_req_o), 32'(ack));
        check({req, " vector"}, 32'(vector_o), 32'(vec));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        step(); step();
        // R1: reset state
        check_grant("R1", 0, 0, 16'h0);
        check("R1 status", 32'(status_o), 32'h38);
        rst_n = 1;
        step();

        // Sweep: 32 request patterns x enable x 8 mask settings (R2 R3 R6 R7 R8 R10 R11 R12 R14)
        for (int ie = 0; ie < 2; ie++) begin
            for (int mk = 0; mk < 8; mk++) begin
                for (int rq = 0; rq < 32; rq++) begin
                    bit t, h, m, l, g, mh, mm, ml, ie_exp, hp;
                    int w;
                    logic [15:0] ev;
                    t = rq[4]; h = rq[3]; m = rq[2]; l = rq[1]; g = rq[0];
                    mh = mk[2]; mm = mk[1]; ml = mk[0];
                    // cycle A: configure
                    idle_inputs();
                    mask_wr_i = 1; mask_wdata_i = {1'b1, 3'(mk)};
                    ei_cmd_i = (ie == 1); di_cmd_i = (ie == 0);
                    step();
                    // cycle B: raise requests and sample
                    idle_inputs();
                    trap_i = t; rst_hi_i = h; rst_mid_i = m; rst_lo_i = l; gen_req_i = g;
                    sample_i = 1;
                    step();
                    if (t) w = 1;
                    else if (ie == 1 && !mh && h) w = 2;
                    else if (ie == 1 && !mm && m) w = 3;
                    else if (ie == 1 && !ml && l) w = 4;
                    else if (ie == 1 && g) w = 5;
                    else w = 0;
                    case (w)
                        1: ev = 16'h0024;
                        2: ev = 16'h003C;
                        3: ev = 16'h0034;
                        4: ev = 16'h002C;
                        default: ev = 16'h0;
                    endcase
                    check_grant("R2", w != 0, w == 5, ev);
                    ie_exp = (ie == 1) && (w < 2);
                    hp = h && (w != 2);
                    check("R14 status", 32'(status_o), 32'({ie_exp, mh, mm, ml, hp, m, l}));
                    idle_inputs();
                    step();
                    check("R4 one-cycle", 32'(accept_o), 32'h0);
                end
            end
        end

        // R4: no sampling without strobe
        idle_inputs(); ei_cmd_i = 1; mask_wr_i = 1; mask_wdata_i = 4'h8;
        step();
        idle_inputs(); rst_mid_i = 1;
        step(); step(); step();
        check("R4 no strobe", 32'(accept_o), 32'h0);
        check("R12 level status", 32'(status_o), 32'h42);
        sample_i = 1;
        step();
        sample_i = 0;
        check_grant("R12", 1, 0, 16'h0034);
        step();
        check("R4 grant ends", 32'(accept_o), 32'h0);
        rst_mid_i = 0;

        // R13: trap held high is accepted once and leaves the enable flag (R8)
        idle_inputs(); ei_cmd_i = 1;
        step();
        idle_inputs(); trap_i = 1; sample_i = 1;
        step();
        sample_i = 0;
        check_grant("R13", 1, 0, 16'h0024);
        check("R8 trap keeps ie", 32'(status_o[6]), 32'h1);
        step(); step();
        sample_i = 1;
        step();
        sample_i = 0;
        check("R13 held no retrigger", 32'(accept_o), 32'h0);
        trap_i = 0;
        step();

        // R13: trap pulse dropped before sample
        trap_i = 1;
        step();
        trap_i = 0;
        step();
        sample_i = 1;
        step();
        sample_i = 0;
        check("R13 pulse dropped", 32'(accept_o), 32'h0);
        step();

        // R11: edge latched while not sampled, taken later
        rst_hi_i = 1;
        step();
        rst_hi_i = 0;
        step();
        check("R11 latched", 32'(status_o[2]), 32'h1);
        sample_i = 1;
        step();
        sample_i = 0;
        check_grant("R11", 1, 0, 16'h003C);
        check("R11 latch cleared by accept", 32'(status_o[2]), 32'h0);
        step();

        // R11: latch cleared by mask write, held level does not relatch
        ei_cmd_i = 1; rst_hi_i = 1;
        step();
        ei_cmd_i = 0; mask_wr_i = 1; mask_wdata_i = 4'h8;
        step();
        mask_wr_i = 0;
        step();
        check("R11 clear by write", 32'(status_o[2]), 32'h0);
        sample_i = 1;
        step();
        sample_i = 0;
        check("R11 held no relatch", 32'(accept_o), 32'h0);
        rst_hi_i = 0;

        // R9: disable wins over enable; no maskable grant while disabled
        ei_cmd_i = 1; di_cmd_i = 1;
        step();
        idle_inputs();
        check("R9 di wins", 32'(status_o[6]), 32'h0);
        gen_req_i = 1; sample_i = 1;
        step();
        idle_inputs();
        check("R9 disabled", 32'(accept_o), 32'h0);
        ei_cmd_i = 1;
        step();
        idle_inputs(); gen_req_i = 1; sample_i = 1;
        step();
        idle_inputs();
        check_grant("R7", 1, 1, 16'h0);
        check("R8 ie cleared", 32'(status_o[6]), 32'h0);
        step();

        // R10: masking mid lets low through
        ei_cmd_i = 1; mask_wr_i = 1; mask_wdata_i = 4'h2;
        step();
        idle_inputs(); rst_mid_i = 1; rst_lo_i = 1; sample_i = 1;
        step();
        idle_inputs();
        check_grant("R10", 1, 0, 16'h002C);
        step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule